// File: doc/BRIEF.md
# Processor Bus Command Controller

This controller sits between a processor's local bus and a buffered system bus. When the processor marks the start of a bus cycle, the controller captures the three cycle-status bits and the address. It turns them into exactly one active-low command strobe: memory read, I/O read, memory write or I/O write. It also drives the direction and output-enable pins of external bidirectional data transceivers, and returns an active-low ready after a selectable number of wait states.

One address range can be marked as the register window of an on-board peripheral that sits directly on the local bus. A read that falls in that range still issues its command strobe, but the transceivers stay disabled for the whole cycle. Only the peripheral then drives the local bus. Writes into the range enable the transceivers as usual. Code fetches and data reads from memory share the single memory-read strobe. Status codes that name no supported cycle run to ready without any strobe or enable.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: While reset is low, and afterwards until the first cycle starts, all four command strobes and `xcvr_oe_n` are high, `rdy_n` is high and `xcvr_dir` is low.
- R2: Status (`st_wr`,`st_mem`,`st_data`) = (0,1,x) is a memory read and asserts only `mem_rd_cmd_n`, for both code (`st_data`=0) and data (`st_data`=1) fetches.
- R3: Status (0,0,1) asserts only `io_rd_cmd_n`, (1,1,1) asserts only `mem_wr_cmd_n`, and (1,0,1) asserts only `io_wr_cmd_n`.
- R4: Status and address are captured at a rising edge where `cyc_start_n` is low and no cycle is in progress. The selected strobe and the enable go low right after that edge and return high at the edge that samples `rdy_n` low. At no time is more than one strobe low.
- R5: With `wait_cfg` = N (0..7) captured at the start edge, `rdy_n` is low only in the (N+1)-th clock cycle after the start edge, so the strobe stays low for exactly N+1 cycles.
- R6: `xcvr_dir` equals the captured `st_wr` (1 = write direction) from the start edge, and holds that value until the next cycle starts, including after the cycle ends.
- R7: For a supported cycle, `xcvr_oe_n` is low for the whole time its strobe is low. The one exception is a read inside the peripheral window.
- R8: A read whose captured address lies in the peripheral window keeps `xcvr_oe_n` high for the whole cycle while its read strobe still asserts. The window is the set of addresses equal to `WIN_BASE` on the bits set in `WIN_MASK`; by default that is 0x400 to 0x4FF. Writes in the window enable the transceivers.
- R9: The unsupported status codes (0,0,0), (1,0,0) and (1,1,0) assert no strobe and no enable, but `rdy_n` still goes low after N wait states as in R5.
- R10: While a cycle is in progress, changes on `cyc_start_n`, the status bits, `addr` and `wait_cfg` have no effect on the strobes, the enable, the direction or the ready timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start_n | input | 1 | Active-low cycle start strobe from the processor |
| st_wr | input | 1 | Status: 1 write, 0 read |
| st_mem | input | 1 | Status: 1 memory, 0 I/O |
| st_data | input | 1 | Status: 1 data, 0 code/control |
| addr | input | ADDR_W | Cycle address, compared against the peripheral window |
| wait_cfg | input | WAIT_W | Number of wait states for the cycle |
| mem_rd_cmd_n | output | 1 | Memory read command, active low |
| io_rd_cmd_n | output | 1 | I/O read command, active low |
| mem_wr_cmd_n | output | 1 | Memory write command, active low |
| io_wr_cmd_n | output | 1 | I/O write command, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward system bus |
| xcvr_oe_n | output | 1 | Transceiver output enable, active low |
| rdy_n | output | 1 | Ready returned to the processor, active low |

## Verification
The strobe, the enable and the direction are due in the first clock cycle after the edge that captures the start strobe. Ready is due N+1 cycles after that edge, and the strobes must be back high in the cycle after ready. The driver raises its inputs 2 ns after a rising edge. The monitor samples every output at the falling edge, one cycle behind the start it saw, and counts cycles from there until ready before it pops the expected item. The cycle after ready is checked for release and for the held direction. Some cycles toggle the start strobe and scramble the status, address and wait count mid-cycle; these must leave every sampled value unchanged.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

   localparam int NUM_CMD = 4;

   // strobe index inside the one-hot command vector
   localparam int CMD_MRD  = 0;
   localparam int CMD_IORD = 1;
   localparam int CMD_MWR  = 2;
   localparam int CMD_IOWR = 3;

   typedef struct packed {
      logic wr;
      logic mem;
      logic data;
   } cyc_status_t;

   typedef enum logic {
      SEQ_IDLE   = 1'b0,
      SEQ_ACTIVE = 1'b1
   } seq_state_e;

   // one-hot command for a status code, all zero for unsupported codes
   function automatic logic [NUM_CMD-1:0] status_to_cmd(cyc_status_t s);
      logic [NUM_CMD-1:0] oh;
      oh = '0;
      if (!s.wr && s.mem)
         oh[CMD_MRD] = 1'b1;
      else if (!s.wr && !s.mem && s.data)
         oh[CMD_IORD] = 1'b1;
      else if (s.wr && s.mem && s.data)
         oh[CMD_MWR] = 1'b1;
      else if (s.wr && !s.mem && s.data)
         oh[CMD_IOWR] = 1'b1;
      return oh;
   endfunction

endpackage

// File: rtl/bcc_cycle_decode.sv
module bcc_cycle_decode
   import bcc_pkg::*;
#(
   parameter int              ADDR_W   = 32,
   parameter bit              WIN_EN   = 1'b1,
   parameter logic [ADDR_W-1:0] WIN_BASE = 'h400,
   parameter logic [ADDR_W-1:0] WIN_MASK = '1
)(
   input  cyc_status_t        status,
   input  logic [ADDR_W-1:0]  addr,
   output logic [NUM_CMD-1:0] cmd_oh,
   output logic               oe_allow
);

   logic supported;
   logic win_hit;

   always_comb begin
      cmd_oh    = status_to_cmd(status);
      supported = |cmd_oh;
   end

   generate
      if (WIN_EN) begin : g_win
         localparam logic [ADDR_W-1:0] BASE_M = WIN_BASE & WIN_MASK;
         assign win_hit = ((addr & WIN_MASK) == BASE_M);
      end else begin : g_nowin
         logic unused_addr;
         assign unused_addr = ^addr;
         assign win_hit = 1'b0;
      end
   endgenerate

   // reads into the peripheral window leave the local bus to the peripheral
   assign oe_allow = supported && !(!status.wr && win_hit);

endmodule

// File: rtl/bcc_wait_ctr.sv
module bcc_wait_ctr #(
   parameter int WAIT_W = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WAIT_W-1:0] wait_in,
   input  logic              run,
   output logic              done
);

   logic [WAIT_W-1:0] cnt_q;
   logic [WAIT_W-1:0] limit_q;

   assign done = run && (cnt_q == limit_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         limit_q <= '0;
      end else if (load) begin
         cnt_q   <= '0;
         limit_q <= wait_in;
      end else if (run && !done) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/bcc_cmd_seq.sv
module bcc_cmd_seq
   import bcc_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cyc_start_n,
   input  logic               st_wr,
   input  logic [NUM_CMD-1:0] cmd_oh,
   input  logic               oe_allow,
   input  logic               done,
   output logic               start,
   output logic               busy,
   output logic [NUM_CMD-1:0] strb_q,
   output logic               oe_q,
   output logic               dir_q
);

   seq_state_e state_q;

   assign start = (state_q == SEQ_IDLE) && !cyc_start_n;
   assign busy  = (state_q == SEQ_ACTIVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         strb_q  <= '0;
         oe_q    <= 1'b0;
         dir_q   <= 1'b0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q <= SEQ_ACTIVE;
                  strb_q  <= cmd_oh;
                  oe_q    <= oe_allow;
                  dir_q   <= st_wr;
               end
            end
            SEQ_ACTIVE: begin
               if (done) begin
                  state_q <= SEQ_IDLE;
                  strb_q  <= '0;
                  oe_q    <= 1'b0;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
   import bcc_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter int                WAIT_W   = 3,
   parameter bit                WIN_EN   = 1'b1,
   parameter logic [ADDR_W-1:0] WIN_BASE = 'h0000_0400,
   parameter logic [ADDR_W-1:0] WIN_MASK = 'hFFFF_FF00
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_start_n,
   input  logic              st_wr,
   input  logic              st_mem,
   input  logic              st_data,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WAIT_W-1:0] wait_cfg,
   output logic              mem_rd_cmd_n,
   output logic              io_rd_cmd_n,
   output logic              mem_wr_cmd_n,
   output logic              io_wr_cmd_n,
   output logic              xcvr_dir,
   output logic              xcvr_oe_n,
   output logic              rdy_n
);

   initial begin
      if (ADDR_W < 1)
         $error("bus_cmd_ctrl: ADDR_W must be positive");
      if (WAIT_W < 1 || WAIT_W > 8)
         $error("bus_cmd_ctrl: WAIT_W must be 1..8");
   end

   cyc_status_t        status;
   logic [NUM_CMD-1:0] cmd_oh;
   logic               oe_allow;
   logic               start;
   logic               busy;
   logic               done;
   logic [NUM_CMD-1:0] strb_q;
   logic [NUM_CMD-1:0] strb_n;
   logic               oe_q;

   assign status = '{wr: st_wr, mem: st_mem, data: st_data};

   bcc_cycle_decode #(
      .ADDR_W   (ADDR_W),
      .WIN_EN   (WIN_EN),
      .WIN_BASE (WIN_BASE),
      .WIN_MASK (WIN_MASK)
   ) u_decode (
      .status   (status),
      .addr     (addr),
      .cmd_oh   (cmd_oh),
      .oe_allow (oe_allow)
   );

   bcc_cmd_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cyc_start_n (cyc_start_n),
      .st_wr       (st_wr),
      .cmd_oh      (cmd_oh),
      .oe_allow    (oe_allow),
      .done        (done),
      .start       (start),
      .busy        (busy),
      .strb_q      (strb_q),
      .oe_q        (oe_q),
      .dir_q       (xcvr_dir)
   );

   bcc_wait_ctr #(
      .WAIT_W (WAIT_W)
   ) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start),
      .wait_in (wait_cfg),
      .run     (busy),
      .done    (done)
   );

   generate
      for (genvar i = 0; i < NUM_CMD; i++) begin : g_strb
         assign strb_n[i] = ~strb_q[i];
      end
   endgenerate

   assign mem_rd_cmd_n = strb_n[CMD_MRD];
   assign io_rd_cmd_n  = strb_n[CMD_IORD];
   assign mem_wr_cmd_n = strb_n[CMD_MWR];
   assign io_wr_cmd_n  = strb_n[CMD_IOWR];
   assign xcvr_oe_n    = ~oe_q;
   assign rdy_n        = ~done;

endmodule

// File: rtl/bcc_chk.sv
module bcc_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cyc_start_n,
   input logic       busy,
   input logic [3:0] strb_n,
   input logic       xcvr_oe_n,
   input logic       xcvr_dir,
   input logic       rdy_n
);

   // R4
   single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~strb_n));

   // R4
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cyc_start_n) |=> busy);

   // R10
   hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rdy_n) |=> (busy && $stable(strb_n) && $stable(xcvr_oe_n) && $stable(xcvr_dir)));

   // R5
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy_n |=> (!busy && (&strb_n) && xcvr_oe_n));

   // R9
   ready_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy_n |-> busy);

   // R7
   oe_with_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xcvr_oe_n |-> !(&strb_n));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ((&strb_n) && xcvr_oe_n && rdy_n));

endmodule

bind bus_cmd_ctrl bcc_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cyc_start_n (cyc_start_n),
   .busy        (busy),
   .strb_n      ({io_wr_cmd_n, mem_wr_cmd_n, io_rd_cmd_n, mem_rd_cmd_n}),
   .xcvr_oe_n   (xcvr_oe_n),
   .xcvr_dir    (xcvr_dir),
   .rdy_n       (rdy_n)
);

// File: tb/test_bus_cmd_ctrl.sv
module test_bus_cmd_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_start_n = 1'b1;
   logic        st_wr = 1'b0, st_mem = 1'b0, st_data = 1'b0;
   logic [31:0] addr = '0;
   logic [2:0]  wait_cfg = '0;
   logic        mem_rd_cmd_n, io_rd_cmd_n, mem_wr_cmd_n, io_wr_cmd_n;
   logic        xcvr_dir, xcvr_oe_n, rdy_n;

   int vectors = 0;
   int miscompares = 0;
   bit done_flag = 1'b0;

   always #4 clk = ~clk;

   bus_cmd_ctrl i_bus_cmd_ctrl (
      .clk, .rst_n, .cyc_start_n, .st_wr, .st_mem, .st_data, .addr, .wait_cfg,
      .mem_rd_cmd_n, .io_rd_cmd_n, .mem_wr_cmd_n, .io_wr_cmd_n,
      .xcvr_dir, .xcvr_oe_n, .rdy_n
   );

   // item: [8] dir, [7] oe active, [6:3] strobes active-high {iowr,mwr,iord,mrd}, [2:0] waits
   logic [8:0] exp_q[$];
   string      tag_q[$];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] port_strb();
      return {~io_wr_cmd_n, ~mem_wr_cmd_n, ~io_rd_cmd_n, ~mem_rd_cmd_n};
   endfunction

   // driver: pushes the expected item, then runs one bus cycle
   task automatic run_cyc(string tag, logic wr, logic mem, logic data,
                          logic [31:0] a, int w, bit disturb);
      logic [3:0] s;
      logic       sup, hit, oe;
      s = 4'b0000;
      if (!wr && mem)               s = 4'b0001;
      else if (!wr && !mem && data) s = 4'b0010;
      else if (wr && mem && data)   s = 4'b0100;
      else if (wr && !mem && data)  s = 4'b1000;
      sup = |s;
      hit = (a[31:8] == 24'h000004);
      oe  = sup && !(!wr && hit);
      exp_q.push_back({wr, oe, s, w[2:0]});
      tag_q.push_back(tag);
      @(posedge clk); #2;
      st_wr = wr; st_mem = mem; st_data = data; addr = a;
      wait_cfg = w[2:0]; cyc_start_n = 1'b0;
      @(posedge clk); #2;
      if (disturb) begin
         cyc_start_n = 1'b0;
         st_wr = ~wr; st_mem = ~mem; st_data = ~data;
         addr = a ^ 32'h0000_0400;
         wait_cfg = ~w[2:0];
      end else begin
         cyc_start_n = 1'b1;
      end
      do @(negedge clk); while (rdy_n !== 1'b0);
      @(posedge clk); #2;
      cyc_start_n = 1'b1;
   endtask

   // monitor: one cycle behind a seen start, compare each cycle, pop at ready
   bit         pending = 0, active = 0, release_chk = 0;
   int         cnt = 0;
   logic [8:0] cur;
   string      cur_tag;

   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         if (release_chk) begin
            release_chk = 0;
            chk({cur_tag, " R4 strobes released"}, {28'd0, port_strb()}, 32'd0);
            chk({cur_tag, " R4 oe released"}, {31'd0, xcvr_oe_n}, 32'd1);
            chk({cur_tag, " R6 dir held"}, {31'd0, xcvr_dir}, {31'd0, cur[8]});
         end
         if (pending) begin
            pending = 0;
            active  = 1;
            cnt     = 0;
            if (exp_q.size() == 0) begin
               chk("R4 unexpected cycle", 32'd1, 32'd0);
               active = 0;
            end else begin
               cur     = exp_q[0];
               cur_tag = tag_q[0];
            end
         end
         if (active) begin
            chk({cur_tag, " R2/R3/R9 strobe"}, {28'd0, port_strb()}, {28'd0, cur[6:3]});
            chk({cur_tag, " R7/R8 oe"}, {31'd0, ~xcvr_oe_n}, {31'd0, cur[7]});
            chk({cur_tag, " R6 dir"}, {31'd0, xcvr_dir}, {31'd0, cur[8]});
            if (rdy_n === 1'b0) begin
               chk({cur_tag, " R5 ready cycle"}, cnt, {29'd0, cur[2:0]});
               void'(exp_q.pop_front());
               void'(tag_q.pop_front());
               active = 0;
               release_chk = 1;
            end else begin
               cnt++;
               if (cnt > 9) begin
                  chk({cur_tag, " R5 ready missing"}, cnt, {29'd0, cur[2:0]});
                  active = 0;
               end
            end
         end else if (!release_chk && cyc_start_n === 1'b0) begin
            pending = 1;
         end
      end
   end

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 strobes in reset", {28'd0, port_strb()}, 32'd0);
      chk("R1 oe in reset", {31'd0, xcvr_oe_n}, 32'd1);
      chk("R1 rdy in reset", {31'd0, rdy_n}, 32'd1);
      chk("R1 dir in reset", {31'd0, xcvr_dir}, 32'd0);
      @(posedge clk); #2 rst_n = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R1 idle after reset", {27'd0, port_strb(), xcvr_oe_n}, 32'd1);

      run_cyc("R2 mem data read",  1'b0, 1'b1, 1'b1, 32'h0000_1000, 2, 1'b0);
      run_cyc("R2 mem code read",  1'b0, 1'b1, 1'b0, 32'h0000_2004, 0, 1'b0);
      run_cyc("R3 io read",        1'b0, 1'b0, 1'b1, 32'h0000_0060, 1, 1'b0);
      run_cyc("R3 mem write",      1'b1, 1'b1, 1'b1, 32'h0001_0000, 3, 1'b0);
      run_cyc("R3 io write",       1'b1, 1'b0, 1'b1, 32'h0000_0080, 7, 1'b0);
      run_cyc("R5 zero wait write",1'b1, 1'b1, 1'b1, 32'h0000_3000, 0, 1'b0);
      run_cyc("R8 mem read window",1'b0, 1'b1, 1'b1, 32'h0000_0410, 1, 1'b0);
      run_cyc("R8 io read window", 1'b0, 1'b0, 1'b1, 32'h0000_0400, 0, 1'b0);
      run_cyc("R8 window top",     1'b0, 1'b1, 1'b0, 32'h0000_04FF, 2, 1'b0);
      run_cyc("R7 below window",   1'b0, 1'b1, 1'b1, 32'h0000_03FF, 1, 1'b0);
      run_cyc("R7 above window",   1'b0, 1'b0, 1'b1, 32'h0000_0500, 1, 1'b0);
      run_cyc("R8 write window",   1'b1, 1'b1, 1'b1, 32'h0000_0480, 2, 1'b0);
      run_cyc("R8 io write window",1'b1, 1'b0, 1'b1, 32'h0000_0420, 0, 1'b0);
      run_cyc("R9 code 000",       1'b0, 1'b0, 1'b0, 32'h0000_0000, 2, 1'b0);
      run_cyc("R9 code 100",       1'b1, 1'b0, 1'b0, 32'h0000_0000, 0, 1'b0);
      run_cyc("R9 code 110",       1'b1, 1'b1, 1'b0, 32'h0000_0002, 5, 1'b0);
      run_cyc("R10 read disturbed",1'b0, 1'b1, 1'b1, 32'h0000_0010, 4, 1'b1);
      run_cyc("R10 win disturbed", 1'b0, 1'b0, 1'b1, 32'h0000_0440, 3, 1'b1);
      run_cyc("R10 wr disturbed",  1'b1, 1'b0, 1'b1, 32'h0000_0044, 6, 1'b1);
      run_cyc("R6 read after wr",  1'b0, 1'b1, 1'b1, 32'h0000_5000, 1, 1'b0);

      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R4 all cycles seen", exp_q.size(), 32'd0);
      chk("R4 idle at end", {27'd0, port_strb(), xcvr_oe_n}, 32'd1);
      done_flag = 1'b1;
      summary();
      $finish;
   end

endmodule